// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a free-running watchdog that asks for a system reset when software stops servicing it. Software controls it through a small register window: a key register that accepts 16-bit magic codes, a divider register, a reload register and a status register. One code starts the watchdog. Another reloads the down-counter ("feed"). A third opens the divider and reload registers for writing, and a fourth closes them again. Once started, the watchdog cannot be stopped by any write. Only a synchronous reset clears it.

The counter is 12 bits wide. It steps down once per divided tick, and the divider ratio is four times a power of two. When a tick arrives with the counter at zero, the block raises a single-cycle reset request and reloads the counter. A new divider or reload value does not take effect at once. It waits in a staging register for a fixed synchronisation delay, and a busy bit in the status register stays set until the value has been applied. The divider and reload registers always read as zero, so software cannot learn the running setup from them. After a start, software writes the values again.

Top module: `key_watchdog`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0, the reset request output is low, and no reset request appears while the watchdog has not been started.
- R2: Writing 0xCCCC to the key register (offset 0x00) starts the watchdog. The reset request goes high exactly (reload+1) × 4 × 2^div clock cycles after the write edge and stays high for exactly one cycle.
- R3: Writing 0xAAAA to the key register reloads the counter and restarts the divider, so the next reset request comes one full period after that write. No request is seen in the cycle after a feed.
- R4: While locked, writes to the divider register (offset 0x04) or the reload register (offset 0x08) are dropped. No busy bit rises, and the expiry period does not change.
- R5: Writing 0x5555 to the key register unlocks the divider and reload registers. Writing 0x0000 locks them again. Reset leaves them locked.
- R6: A write to the divider register sets status bit 0, and a write to the reload register sets status bit 1. Each bit stays set for exactly SYNC_CYCLES clock cycles (default 3) and then clears, and the new value takes effect in the same cycle the bit clears.
- R7: A key value other than 0xCCCC, 0xAAAA, 0x5555 or 0x0000 has no effect. It does not feed the counter and does not unlock.
- R8: Once started, the watchdog keeps running after a lock key or any other write. After an expiry it reloads by itself, so without feeding, reset requests repeat at the full period.
- R9: The divider register takes an unsigned value. Any value above MAX_PR (default 6) acts as MAX_PR, giving a largest ratio of 256.
- R10: Reads of the divider and reload registers return 0. The reload register uses bits 11:0 of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | ADDR_W (5) | Byte offset of the register being written or read |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Combinational read data for bus_addr |
| wdg_rst_o | output | 1 | One-cycle reset request on expiry |

## Verification
A write is captured on the rising edge E, and the status register shows its busy bit from the falling edge right after E. The busy bit is still set after edge E+SYNC_CYCLES-1 and has cleared after edge E+SYNC_CYCLES. The reset request is registered, so it is first seen after edge E+(reload+1)×ratio for a start or feed captured at E. It is gone one cycle later. The bench changes inputs and samples outputs only on falling edges, and counts falling edges from the write, so each check lands on the exact cycle the requirement names.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int KEY_W = 16;

    localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_FEED   = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_LOCK   = 16'h0000;

    localparam int OFS_KEY  = 'h00;
    localparam int OFS_DIV  = 'h04;
    localparam int OFS_RLD  = 'h08;
    localparam int OFS_STAT = 'h0C;

    typedef enum logic [2:0] {
        KC_NOP,
        KC_START,
        KC_FEED,
        KC_UNLOCK,
        KC_LOCK
    } key_cmd_e;

    typedef struct packed {
        logic rld_busy;   // bit 1
        logic div_busy;   // bit 0
    } wdg_stat_t;

    function automatic key_cmd_e decode_key(input logic [KEY_W-1:0] k);
        case (k)
            KEY_START:  return KC_START;
            KEY_FEED:   return KC_FEED;
            KEY_UNLOCK: return KC_UNLOCK;
            KEY_LOCK:   return KC_LOCK;
            default:    return KC_NOP;
        endcase
    endfunction

endpackage

// File: rtl/wdg_keyctl.sv
module wdg_keyctl
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    output logic             running,
    output logic             unlocked,
    output logic             reload_req
);

    key_cmd_e cmd;

    assign cmd = key_wr ? decode_key(key_val) : KC_NOP;

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            unlocked <= 1'b0;
        end else begin
            case (cmd)
                KC_START:  running  <= 1'b1;
                KC_UNLOCK: unlocked <= 1'b1;
                KC_LOCK:   unlocked <= 1'b0;
                default:   ;
            endcase
        end
    end

    assign reload_req = (cmd == KC_START) || (cmd == KC_FEED);

    // R8: nothing but reset stops a started watchdog
    a_r8_no_stop: assert property (@(posedge clk) disable iff (rst)
        running |=> running);

endmodule

// File: rtl/wdg_shadow.sv
module wdg_shadow #(
    parameter int         W    = 12,
    parameter int         SYNC = 3,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] active,
    output logic         busy
);

    localparam int CW = $clog2(SYNC + 1);

    logic [W-1:0]  staged;
    logic [CW-1:0] dly;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= INIT;
            active <= INIT;
            dly    <= '0;
        end else if (wr) begin
            staged <= wdata;
            dly    <= CW'(SYNC);
        end else if (dly != '0) begin
            dly <= dly - CW'(1);
            if (dly == CW'(1)) begin
                active <= staged;
            end
        end
    end

    assign busy = (dly != '0);

    // R6: the value in use changes only when the busy flag drops
    a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr) |=> (!busy || $stable(active)));

    // R6: when busy drops the staged value is the one in use
    a_r6_value_on_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (active == $past(staged)));

endmodule

// File: rtl/wdg_tick.sv
module wdg_tick #(
    parameter int MAX_PR = 6,
    parameter int PR_W   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            running,
    input  logic            restart,
    input  logic [PR_W-1:0] pr,
    output logic            tick
);

    localparam int DW = MAX_PR + 3;

    logic [DW-1:0] div;
    logic [DW-1:0] last;

    assign last = (DW'(4) << pr) - DW'(1);
    assign tick = running && !restart && (div >= last);

    always_ff @(posedge clk) begin
        if (rst || !running || restart || tick) begin
            div <= '0;
        end else begin
            div <= div + DW'(1);
        end
    end

endmodule

// File: rtl/wdg_downcnt.sv
module wdg_downcnt #(
    parameter int RL_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            reload_req,
    input  logic [RL_W-1:0] reload,
    output logic            expire
);

    logic [RL_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '1;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (reload_req) begin
                cnt <= reload;
            end else if (tick) begin
                if (cnt == '0) begin
                    expire <= 1'b1;
                    cnt    <= reload;
                end else begin
                    cnt <= cnt - RL_W'(1);
                end
            end
        end
    end

    // R2: the reset request lasts exactly one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
    import wdg_pkg::*;
#(
    parameter int RL_W        = 12,
    parameter int MAX_PR      = 6,
    parameter int SYNC_CYCLES = 3,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdg_rst_o
);

    localparam int PR_W = $clog2(MAX_PR + 1);

    logic            sel_key, sel_div, sel_rld, sel_stat;
    logic            running, unlocked, reload_req, tick;
    logic [PR_W-1:0] pr_in, pr_act;
    logic [RL_W-1:0] rl_act;
    wdg_stat_t       stat;

    assign sel_key  = (bus_addr == ADDR_W'(OFS_KEY));
    assign sel_div  = (bus_addr == ADDR_W'(OFS_DIV));
    assign sel_rld  = (bus_addr == ADDR_W'(OFS_RLD));
    assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));

    assign pr_in = (bus_wdata > DATA_W'(MAX_PR)) ? PR_W'(MAX_PR)
                                                 : bus_wdata[PR_W-1:0];

    wdg_keyctl u_keyctl (
        .clk        (clk),
        .rst        (rst),
        .key_wr     (bus_wr && sel_key),
        .key_val    (bus_wdata[KEY_W-1:0]),
        .running    (running),
        .unlocked   (unlocked),
        .reload_req (reload_req)
    );

    wdg_shadow #(.W(PR_W), .SYNC(SYNC_CYCLES), .INIT('0)) u_div_shadow (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr && sel_div && unlocked),
        .wdata  (pr_in),
        .active (pr_act),
        .busy   (stat.div_busy)
    );

    wdg_shadow #(.W(RL_W), .SYNC(SYNC_CYCLES), .INIT('1)) u_rld_shadow (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr && sel_rld && unlocked),
        .wdata  (bus_wdata[RL_W-1:0]),
        .active (rl_act),
        .busy   (stat.rld_busy)
    );

    wdg_tick #(.MAX_PR(MAX_PR), .PR_W(PR_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .running (running),
        .restart (reload_req),
        .pr      (pr_act),
        .tick    (tick)
    );

    wdg_downcnt #(.RL_W(RL_W)) u_downcnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .reload_req (reload_req),
        .reload     (rl_act),
        .expire     (wdg_rst_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_stat) begin
            bus_rdata[1:0] = stat;
        end
    end

    // R4: locked writes never start a divider update
    a_r4_locked_drop_div: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel_div && !unlocked) |=> !$rose(stat.div_busy));

    // R4: locked writes never start a reload update
    a_r4_locked_drop_rld: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel_rld && !unlocked) |=> !$rose(stat.rld_busy));

    // R3: a feed leaves no request in the following cycle
    a_r3_feed_no_pulse: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel_key && (bus_wdata[KEY_W-1:0] == KEY_FEED)) |=> !wdg_rst_o);

endmodule

// File: tb/test_key_watchdog.sv
module test_key_watchdog;

    localparam int MAX_PR = 6;
    localparam int SYNC   = 3;
    localparam int NVEC   = 6;

    // vector table: divider value, reload value
    localparam int VPR [NVEC] = '{0, 1, 2, 7, 0, 3};
    localparam int VRL [NVEC] = '{2, 5, 3, 1, 0, 10};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wdg_rst_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    key_watchdog i_key_watchdog (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wdg_rst_o (wdg_rst_o)
    );

    function automatic int period(input int pr, input int rl);
        int p;
        p = (pr > MAX_PR) ? MAX_PR : pr;
        return (rl + 1) * (4 << p);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 5'(addr);
        bus_wdata = 16'(data);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        bus_addr = 5'(addr);
        #1;
        data = int'(bus_rdata);
    endtask

    task automatic wait_pulse(input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (wdg_rst_o) return;
        end
        n = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung run expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, n, pulses;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state and idle behaviour
        rd('h0C, v);
        check("R1 status after reset", v, 0);
        check("R1 request low after reset", int'(wdg_rst_o), 0);
        pulses = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (wdg_rst_o) pulses++;
        end
        check("R1 no request before start", pulses, 0);

        // R6: busy flag timing for the divider and reload registers
        wr('h00, 'h5555);
        wr('h04, 0);
        rd('h0C, v);
        check("R6 div busy right after write", v, 1);
        repeat (SYNC - 1) @(negedge clk);
        rd('h0C, v);
        check("R6 div busy at last busy cycle", v, 1);
        @(negedge clk);
        rd('h0C, v);
        check("R6 div busy cleared", v, 0);
        wr('h08, 'hF005);
        rd('h0C, v);
        check("R6 rld busy right after write", v, 2);
        repeat (SYNC) @(negedge clk);
        rd('h0C, v);
        check("R6 rld busy cleared", v, 0);

        // R10: configuration registers read as zero
        rd('h04, v);
        check("R10 divider reads zero", v, 0);
        rd('h08, v);
        check("R10 reload reads zero", v, 0);

        // vector table: R2 start, R3 feed, R9 clamp, R10 reload field
        for (int i = 0; i < NVEC; i++) begin
            wr('h00, 'h5555);
            wr('h04, VPR[i]);
            wr('h08, VRL[i]);
            repeat (SYNC + 1) @(negedge clk);
            rd('h0C, v);
            check("R6 updates settled", v, 0);
            wr('h00, (i == 0) ? 'hCCCC : 'hAAAA);
            wait_pulse(20000, n);
            check((i == 0) ? "R2 period after start" :
                  (VPR[i] > MAX_PR) ? "R9 clamped period" : "R3 period after feed",
                  n, period(VPR[i], VRL[i]));
            @(negedge clk);
            check("R2 request one cycle wide", int'(wdg_rst_o), 0);
        end

        // R4 and R5: lock key drops configuration writes
        wr('h00, 'h0000);
        wr('h08, 'h0FF);
        rd('h0C, v);
        check("R4 locked reload write dropped", v, 0);
        wr('h04, 0);
        rd('h0C, v);
        check("R4 locked divider write dropped", v, 0);
        wr('h00, 'hAAAA);
        wait_pulse(20000, n);
        check("R4 period unchanged after locked writes", n, period(3, 10));

        // R7: unknown key neither feeds nor unlocks
        wr('h00, 'hAAAA);
        repeat (99) @(negedge clk);
        wr('h00, 'h1234);
        wait_pulse(20000, n);
        check("R7 unknown key does not feed", n, period(3, 10) - 101);
        wr('h04, 1);
        rd('h0C, v);
        check("R7 unknown key does not unlock", v, 0);

        // R5: unlock opens the registers again
        wr('h00, 'h5555);
        wr('h04, 1);
        rd('h0C, v);
        check("R5 unlock accepts divider write", v, 1);
        repeat (SYNC) @(negedge clk);

        // R8: lock does not stop, expiry repeats by itself
        wr('h00, 'h0000);
        wr('h00, 'hAAAA);
        wait_pulse(20000, n);
        check("R8 period after lock and feed", n, period(1, 10));
        wait_pulse(20000, n);
        check("R8 self-reloading repeat", n, period(1, 10));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule